// File: doc/BRIEF.md
# Pipeline Control Unit with Branch Delay Slot and Squash

This block is the control section of an in-order five-stage pipeline with the stages fetch, decode, execute, memory and write-back. Each clock it latches the word fetched from instruction memory and decodes it into a bundle of control fields and a valid bit. The bundle then moves down the stage registers alongside the instruction, and each stage keeps only the fields that it and the later stages still need. The datapath, the register file and both memories sit outside the block. The block drives their control inputs: the register read addresses and raw immediate in decode, the ALU operation and operand selects in execute, the memory strobes in the memory stage, and the register-file write controls in write-back.

Every instruction that writes the register file does so in stage 5, so the single write port never has two users in one cycle. ALU instructions pass through the memory stage with no memory access. A branch compares for equality in execute, using a flag that the datapath returns. When the branch is taken, the block asks for the branch target to be loaded into the PC. Fetch runs sequentially until then. The instruction right after the branch completes as a delay slot, and the instruction after that one is squashed by clearing its valid bit.

Top module: `pipe_ctrl`

## Requirements
- R1: An instruction presented on `if_instr` before clock edge n is in decode after edge n, drives the execute outputs after edge n+1, the memory strobes after edge n+2 and the write-back outputs after edge n+3. There is no stall.
- R2: Decode uses opcode bits [31:26] and function bits [5:0]. R-type (opcode 0) function 0x20 is add, 0x22 is sub, 0x24 is and and 0x25 is or. Opcode 0x08 is add-immediate, 0x0D is or-immediate, 0x23 is load, 0x2B is store and 0x04 is branch-if-equal. `ex_alu_op` encodes 0 = add, 1 = subtract, 2 = and, 3 = or. Load, store and add-immediate use add, and the branch uses subtract.
- R3: R-type instructions write rd (bits [15:11]) and immediate ALU instructions write rt (bits [20:16]). Both write in the write-back stage with `wb_from_mem` low, and neither raises a memory strobe.
- R4: A load raises `mem_rd` in the memory stage and then writes rt in write-back with `wb_from_mem` high.
- R5: A store raises `mem_wr` in the memory stage and never asserts `wb_we`.
- R6: In execute, `ex_use_imm` is high for add-immediate, or-immediate, load and store. `ex_imm_zero` is high only for or-immediate (zero extension). All the others sign-extend.
- R7: `pc_take_branch` is high while a valid branch is in execute and `ex_equal` is high. A branch with `ex_equal` low lets every following instruction complete.
- R8: After a taken branch, the instruction in decode (the delay slot) completes normally. The instruction fetched in that same cycle is squashed: it raises no overflow check, no memory strobe and no register write.
- R9: `ex_ovf_chk` is high only for a valid add, sub or add-immediate in execute.
- R10: An unknown opcode, or an R-type with an unknown function code, behaves as a no-op: no strobe, no write, no overflow check and no branch.
- R11: While `rst_n` is low, every stage is invalid and all strobes, write enables and `pc_take_branch` are low.
- R12: `mem_rd` and `mem_wr` are never high together.
- R13: In decode, `id_rs_addr`, `id_rt_addr` and `id_imm` carry bits [25:21], [20:16] and [15:0] of the instruction held there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_instr | input | 32 | Word fetched this cycle |
| ex_equal | input | 1 | Operand-equality flag from the execute datapath |
| id_rs_addr | output | 5 | First register read address |
| id_rt_addr | output | 5 | Second register read address |
| id_imm | output | 16 | Raw immediate field in decode |
| ex_alu_op | output | 2 | ALU operation for execute |
| ex_use_imm | output | 1 | Second ALU operand is the immediate |
| ex_imm_zero | output | 1 | Zero-extend the immediate (sign-extend otherwise) |
| ex_ovf_chk | output | 1 | Check signed overflow this cycle |
| pc_take_branch | output | 1 | Load the branch target into the PC |
| mem_rd | output | 1 | Data-memory read strobe |
| mem_wr | output | 1 | Data-memory write strobe |
| wb_we | output | 1 | Register-file write enable |
| wb_addr | output | 5 | Register-file write address |
| wb_from_mem | output | 1 | Write-back data comes from memory |

## Verification
The block has no parameters, because the 32-bit instruction format fixes every width. The bench therefore builds it as written. The fixed stage count lets the expected value of every output be placed at an exact step after the instruction enters. A single stream mixes a load, ALU instructions, a taken branch followed by its delay slot and a squashed add, a store, an unknown opcode and the all-zero word. Directed runs add a branch that is not taken, a reset that arrives while a load is in flight, and checks of the ALU operation codes.

// File: rtl/pipe_ctrl.sv
module pipe_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] if_instr,
  input  logic        ex_equal,
  output logic [4:0]  id_rs_addr,
  output logic [4:0]  id_rt_addr,
  output logic [15:0] id_imm,
  output logic [1:0]  ex_alu_op,
  output logic        ex_use_imm,
  output logic        ex_imm_zero,
  output logic        ex_ovf_chk,
  output logic        pc_take_branch,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        wb_we,
  output logic [4:0]  wb_addr,
  output logic        wb_from_mem
);

  localparam logic [1:0] ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_AND = 2'd2, ALU_OR = 2'd3;

  // decode stage
  logic [31:0] id_ir;
  logic        id_v;

  // decoded bundle
  logic [1:0] d_alu;
  logic       d_imm, d_zx, d_ovf, d_br, d_mrd, d_mwr, d_we, d_fm, d_dst_rd;
  logic [4:0] d_dst;

  // execute stage
  logic       x_v, x_imm, x_zx, x_ovf, x_br, x_mrd, x_mwr, x_we, x_fm;
  logic [1:0] x_alu;
  logic [4:0] x_dst;

  // memory stage
  logic       m_v, m_rd, m_wr, m_we, m_fm;
  logic [4:0] m_dst;

  // write-back stage
  logic       w_v, w_we, w_fm;
  logic [4:0] w_dst;

  always_comb begin
    d_alu = ALU_ADD; d_imm = 1'b0; d_zx = 1'b0; d_ovf = 1'b0; d_br = 1'b0;
    d_mrd = 1'b0; d_mwr = 1'b0; d_we = 1'b0; d_fm = 1'b0; d_dst_rd = 1'b0;
    case (id_ir[31:26])
      6'h00: begin
        d_dst_rd = 1'b1;
        case (id_ir[5:0])
          6'h20: begin d_alu = ALU_ADD; d_ovf = 1'b1; d_we = 1'b1; end
          6'h22: begin d_alu = ALU_SUB; d_ovf = 1'b1; d_we = 1'b1; end
          6'h24: begin d_alu = ALU_AND; d_we = 1'b1; end
          6'h25: begin d_alu = ALU_OR;  d_we = 1'b1; end
          default: ;
        endcase
      end
      6'h08: begin d_imm = 1'b1; d_ovf = 1'b1; d_we = 1'b1; end
      6'h0D: begin d_alu = ALU_OR; d_imm = 1'b1; d_zx = 1'b1; d_we = 1'b1; end
      6'h23: begin d_imm = 1'b1; d_mrd = 1'b1; d_we = 1'b1; d_fm = 1'b1; end
      6'h2B: begin d_imm = 1'b1; d_mwr = 1'b1; end
      6'h04: begin d_alu = ALU_SUB; d_br = 1'b1; end
      default: ;
    endcase
  end

  assign d_dst = d_dst_rd ? id_ir[15:11] : id_ir[20:16];

  assign id_rs_addr = id_ir[25:21];
  assign id_rt_addr = id_ir[20:16];
  assign id_imm     = id_ir[15:0];

  assign pc_take_branch = x_v & x_br & ex_equal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_ir <= '0; id_v <= 1'b0;
      x_v <= 1'b0; x_alu <= ALU_ADD; x_imm <= 1'b0; x_zx <= 1'b0; x_ovf <= 1'b0;
      x_br <= 1'b0; x_mrd <= 1'b0; x_mwr <= 1'b0; x_we <= 1'b0; x_fm <= 1'b0; x_dst <= '0;
      m_v <= 1'b0; m_rd <= 1'b0; m_wr <= 1'b0; m_we <= 1'b0; m_fm <= 1'b0; m_dst <= '0;
      w_v <= 1'b0; w_we <= 1'b0; w_fm <= 1'b0; w_dst <= '0;
    end else begin
      id_ir <= if_instr;
      id_v  <= ~pc_take_branch;
      x_v <= id_v; x_alu <= d_alu; x_imm <= d_imm; x_zx <= d_zx; x_ovf <= d_ovf;
      x_br <= d_br; x_mrd <= d_mrd; x_mwr <= d_mwr; x_we <= d_we; x_fm <= d_fm; x_dst <= d_dst;
      m_v <= x_v; m_rd <= x_mrd; m_wr <= x_mwr; m_we <= x_we; m_fm <= x_fm; m_dst <= x_dst;
      w_v <= m_v; w_we <= m_we; w_fm <= m_fm; w_dst <= m_dst;
    end
  end

  assign ex_alu_op   = x_alu;
  assign ex_use_imm  = x_imm;
  assign ex_imm_zero = x_zx;
  assign ex_ovf_chk  = x_v & x_ovf;
  assign mem_rd      = m_v & m_rd;
  assign mem_wr      = m_v & m_wr;
  assign wb_we       = w_v & w_we;
  assign wb_addr     = w_dst;
  assign wb_from_mem = w_fm;

  always @(posedge clk)
    if (!rst_n)
      assert_quiet_in_reset_R11: assert (!wb_we && !mem_rd && !mem_wr && !pc_take_branch && !ex_ovf_chk)
        else $error("activity during reset");

  assert_one_mem_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_squash_no_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_take_branch |=> ##1 !ex_ovf_chk);

  assert_squash_no_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_take_branch |=> ##2 (!mem_rd && !mem_wr));

  assert_squash_no_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_take_branch |=> ##3 !wb_we);

  assert_load_reads_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we && wb_from_mem) |-> $past(mem_rd));

  assert_store_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !wb_we);

endmodule

// File: tb/test_pipe_ctrl.sv
`timescale 1ns/1ps
module test_pipe_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] if_instr = '0;
  logic        ex_equal = 1'b0;
  logic [4:0]  id_rs_addr, id_rt_addr, wb_addr;
  logic [15:0] id_imm;
  logic [1:0]  ex_alu_op;
  logic        ex_use_imm, ex_imm_zero, ex_ovf_chk, pc_take_branch;
  logic        mem_rd, mem_wr, wb_we, wb_from_mem;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pipe_ctrl i_pipe_ctrl (
    .clk(clk), .rst_n(rst_n), .if_instr(if_instr), .ex_equal(ex_equal),
    .id_rs_addr(id_rs_addr), .id_rt_addr(id_rt_addr), .id_imm(id_imm),
    .ex_alu_op(ex_alu_op), .ex_use_imm(ex_use_imm), .ex_imm_zero(ex_imm_zero),
    .ex_ovf_chk(ex_ovf_chk), .pc_take_branch(pc_take_branch),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_we(wb_we), .wb_addr(wb_addr),
    .wb_from_mem(wb_from_mem)
  );

  // stream: lw r1; addi r2; sub r3; beq r6,r7; ori r8 (slot); add r10 (squashed);
  //         and r13; sw r16; unknown; or r18; four all-zero words
  localparam logic [31:0] INS [14] = '{
    32'h8C410023, 32'h20420003, 32'h00851822, 32'h10C70010, 32'h35280011,
    32'h016C5020, 32'h01CF6824, 32'hAE300004, 32'hFC1F0000, 32'h02749025,
    32'h0, 32'h0, 32'h0, 32'h0 };
  localparam logic [13:0] E_EQ   = 14'b00_0001_0010_0000;
  localparam logic [13:0] E_TAKE = 14'b00_0000_0010_0000;
  localparam logic [13:0] E_RD   = 14'b00_0000_0000_1000;
  localparam logic [13:0] E_WR   = 14'b00_0100_0000_0000;
  localparam logic [13:0] E_WE   = 14'b10_0101_0111_0000;
  localparam logic [13:0] E_FM   = 14'b00_0000_0001_0000;
  localparam logic [13:0] E_OVF  = 14'b00_0000_0001_1000;
  localparam logic [13:0] E_IZ   = 14'b00_0000_0100_0000;
  localparam logic [4:0]  E_AD [14] = '{5'd0, 5'd0, 5'd0, 5'd0, 5'd1, 5'd2, 5'd3,
                                        5'd0, 5'd8, 5'd0, 5'd13, 5'd0, 5'd0, 5'd18};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] ins, input logic eq);
    @(negedge clk);
    rst_n = 1'b1;
    if_instr = ins;
    ex_equal = eq;
    #1;
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R11 reset wb_we", wb_we, 0);
    check("R11 reset mem strobes", {mem_rd, mem_wr}, 0);
    check("R11 reset take/ovf", {pc_take_branch, ex_ovf_chk}, 0);

    for (int k = 0; k < 14; k++) begin
      step(INS[k], E_EQ[k]);
      check($sformatf("R7 take k=%0d", k), pc_take_branch, E_TAKE[k]);
      check($sformatf("R4 mem_rd k=%0d", k), mem_rd, E_RD[k]);
      check($sformatf("R5 mem_wr k=%0d", k), mem_wr, E_WR[k]);
      check($sformatf("R1 R3 wb_we k=%0d", k), wb_we, E_WE[k]);
      if (E_WE[k]) begin
        check($sformatf("R3 wb_addr k=%0d", k), wb_addr, E_AD[k]);
        check($sformatf("R4 wb_from_mem k=%0d", k), wb_from_mem, E_FM[k]);
      end
      check($sformatf("R9 ovf k=%0d", k), ex_ovf_chk, E_OVF[k]);
      check($sformatf("R6 imm_zero k=%0d", k), ex_imm_zero, E_IZ[k]);
      check($sformatf("R12 strobes k=%0d", k), mem_rd & mem_wr, 0);
      if (k == 7) check("R8 squashed add no ovf", ex_ovf_chk, 0);
      if (k == 8) check("R8 slot ori written", {wb_we, wb_addr}, {1'b1, 5'd8});
      if (k == 9) check("R8 squashed add no write", wb_we, 0);
      if (k == 12) check("R10 unknown op no write", wb_we, 0);
    end

    // reset while a load is in flight
    step(32'h8C410023, 1'b0);
    step(32'h0, 1'b0);
    step(32'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11 reset kills load read", mem_rd, 0);
    @(posedge clk);
    #1;
    check("R11 reset no write", wb_we, 0);

    // not-taken branch beq r1,r1,4 then addi r5, addi r6, or r7
    step(32'h10210004, 1'b0);
    step(32'h20050001, 1'b0);
    check("R13 rs", id_rs_addr, 1);
    check("R13 rt", id_rt_addr, 1);
    check("R13 imm", id_imm, 16'h0004);
    step(32'h20060002, 1'b0);
    check("R7 not taken", pc_take_branch, 0);
    check("R2 beq alu sub", ex_alu_op, 1);
    step(32'h00223825, 1'b0);
    check("R2 addi alu add", ex_alu_op, 0);
    check("R6 addi uses imm", ex_use_imm, 1);
    check("R6 addi sign ext", ex_imm_zero, 0);
    step(32'h0, 1'b0);
    step(32'h0, 1'b0);
    check("R2 or alu", ex_alu_op, 3);
    check("R2 or reg operand", ex_use_imm, 0);
    check("R10 zero word no ovf", ex_ovf_chk, 0);
    check("R7 second after branch written", {wb_we, wb_addr}, {1'b1, 5'd5});
    step(32'h0, 1'b0);
    check("R7 third after branch written", {wb_we, wb_addr}, {1'b1, 5'd6});
    step(32'h0, 1'b0);
    check("R1 R3 or writes rd", {wb_we, wb_addr, wb_from_mem}, {1'b1, 5'd7, 1'b0});
    step(32'h0, 1'b0);
    check("R10 zero word no write", wb_we, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule